// File: doc/BRIEF.md
# Parallel-Indexed Physically-Tagged L1 Cache

This block is a level-one data cache that starts its array read before address translation has finished. Both the set index and the word position within a line come only from the page-offset bits of the virtual address. Those bits are identical in the virtual and the physical address, so the tag and data arrays can be read while a companion TLB looks up the page. Only the last step, the tag compare, waits for the physical page number that the TLB returns. A lookup that hits therefore finishes in a single cycle. There is no TLB cycle followed by a separate cache cycle.

The scheme is legal only when one way holds no more bytes than one page. With 4 KB pages, an 8 KB capacity forces two ways. The default build is 128 sets × 32-byte lines × 2 ways. An elaboration check rejects any parameter set in which the sets times the line size exceed the page. Each stored tag is a physical page number.

On a miss, if the translation is valid, the block requests the whole line from a next-level memory using the line-aligned physical address. It installs the line and its physical tag into a victim way. The requester keeps presenting the same access, and that access then hits; this is the replay. A TLB miss produces neither a hit nor a miss and allocates nothing.

Top module: `pipt_l1_cache`

## Requirements
- R1: The set index is vaddr bits 11:5 and the word select is vaddr bits 4:2. Virtual page bits 31:12 have no effect on the lookup: the same page offset with the same PPN hits whatever the VPN is.
- R2: Each set has two ways. Lines with the same index but different PPNs are resident at the same time, and both hit.
- R3: A lookup with a valid translation drives hit_o or miss_o, plus rdata_o when it hits, combinationally in the same cycle as the request. No clock edge lies in between.
- R4: The stored tag is the physical page number. An access with the same virtual address but a different PPN misses.
- R5: On a hit, rdata_o is word k of the line, where k = vaddr[4:2]. Word k sits at bits 32k+31:32k of refill_data_i.
- R6: When req_i is high and tlb_hit_i is low, hit_o and miss_o stay low and refill_req_o does not rise. Nothing is allocated, so a later access to that page with a valid translation still misses.
- R7: A miss pulses miss_o for one cycle. From the next cycle, refill_req_o holds high with refill_addr_o = {ppn, vaddr[11:5], 5'b0} until refill_valid_i. During that time hit_o and miss_o stay low.
- R8: In the cycle when refill_valid_i is sampled high, the line and its tag are written. The access, still being held by the requester, hits on the following cycle with the refilled data.
- R9: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid. Otherwise the victim is the way used least recently; both hits and fills count as use.
- R10: Reset invalidates every line in both ways, so every first access after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| vaddr_i | input | 32 | Virtual byte address |
| tlb_hit_i | input | 1 | Translation valid from the TLB |
| tlb_ppn_i | input | 20 | Physical page number from the TLB |
| rdata_o | output | 32 | Read word |
| hit_o | output | 1 | Cache hit this cycle |
| miss_o | output | 1 | Cache miss this cycle (one-cycle pulse) |
| refill_req_o | output | 1 | Line refill outstanding |
| refill_addr_o | output | 32 | Line-aligned physical refill address |
| refill_valid_i | input | 1 | Refill line present |
| refill_data_i | input | 256 | Refill line, word k at bits 32k+31:32k |

## Verification
Two functions can fall in the same cycle: the recency update of a hit and the lookup's own compare. The bench makes them collide by hitting one way of a set and then, in the very next access, missing with a third page in that same set. Judging this means predicting the victim from the recency rule alone and confirming which old page still hits afterwards. A second overlap happens when the refill install and the replayed lookup fall on adjacent edges. The bench judges it by sampling hit_o and rdata_o in the cycle right after refill_valid_i is accepted.

// File: rtl/pipt_cache_pkg.sv
package pipt_cache_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } fill_state_t;
endpackage

// File: rtl/pipt_tag_store.sv
module pipt_tag_store #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned SETS  = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             wr_en,
  input  logic [WAYS-1:0]  wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [WAYS-1:0]  way_hit,
  output logic [WAYS-1:0]  way_valid
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q, vld_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_here;

    assign wr_here = wr_en && wr_way[w];

    always_comb begin
      vld_d = vld_q;
      if (wr_here) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (wr_here) tag_q[wr_idx] <= wr_tag;
    end

    // Index read proceeds before translation; only this compare needs the PPN.
    assign way_valid[w] = vld_q[rd_idx];
    assign way_hit[w]   = vld_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
  end
endmodule

// File: rtl/pipt_data_store.sv
module pipt_data_store #(
  parameter int unsigned WAYS   = 2,
  parameter int unsigned SETS   = 128,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned WSEL_W = 3,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_sel,
  input  logic [WAYS-1:0]   way_hit,
  input  logic              wr_en,
  input  logic [WAYS-1:0]   wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINE_W-1:0] line_q [WAYS][SETS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (wr_en && wr_way[w]) line_q[w][wr_idx] <= wr_line;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) rd_word = rd_word | line_q[w][rd_idx][rd_sel*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/pipt_fill_ctrl.sv
module pipt_fill_ctrl
  import pipt_cache_pkg::*;
#(
  parameter int unsigned SETS   = 128,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned PGL_W  = 7,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [PGL_W-1:0]  pg_line,
  input  logic [1:0]        way_hit,
  input  logic [1:0]        way_valid,
  input  logic              refill_valid,
  output logic              hit,
  output logic              miss,
  output logic              refill_req,
  output logic [ADDR_W-1:0] refill_addr,
  output logic              wr_en,
  output logic [1:0]        wr_way,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [PPN_W-1:0]  wr_tag
);
  fill_state_t      st_q, st_d;
  logic [SETS-1:0]  lru_q, lru_d;   // bit = way to evict next
  logic [PPN_W-1:0] mppn_q;
  logic [PGL_W-1:0] mpgl_q;
  logic [1:0]       vict_q, vict_d;
  logic [IDX_W-1:0] idx;
  logic             lookup;

  assign idx    = pg_line[IDX_W-1:0];
  assign lookup = req && tlb_hit && (st_q == ST_LOOKUP);
  assign hit    = lookup && (|way_hit);
  assign miss   = lookup && !(|way_hit);

  assign refill_req  = (st_q == ST_REFILL);
  assign refill_addr = {mppn_q, mpgl_q, {OFF_W{1'b0}}};
  assign wr_en       = refill_req && refill_valid;
  assign wr_way      = vict_q;
  assign wr_idx      = mpgl_q[IDX_W-1:0];
  assign wr_tag      = mppn_q;

  always_comb begin
    if (!way_valid[0])      vict_d = 2'b01;
    else if (!way_valid[1]) vict_d = 2'b10;
    else                    vict_d = lru_q[idx] ? 2'b10 : 2'b01;
  end

  always_comb begin
    st_d  = st_q;
    lru_d = lru_q;
    if (hit) lru_d[idx] = way_hit[0];
    if (miss) st_d = ST_REFILL;
    if (wr_en) begin
      st_d          = ST_LOOKUP;
      lru_d[wr_idx] = vict_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOOKUP;
      lru_q <= '0;
    end else begin
      st_q  <= st_d;
      lru_q <= lru_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss) begin
      mppn_q <= ppn;
      mpgl_q <= pg_line;
      vict_q <= vict_d;
    end
  end
endmodule

// File: rtl/pipt_l1_cache.sv
module pipt_l1_cache
  import pipt_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SETS       = 128,
  localparam int unsigned PPN_W     = ADDR_W - PAGE_BITS,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              refill_req_o,
  output logic [ADDR_W-1:0] refill_addr_o,
  input  logic              refill_valid_i,
  input  logic [LINE_W-1:0] refill_data_i
);
  localparam int unsigned WAYS   = 2;  // one recency bit per set
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned BYTE_W = $clog2(WORD_W / 8);
  localparam int unsigned WSEL_W = OFF_W - BYTE_W;
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned PGL_W  = PAGE_BITS - OFF_W;

  if (SETS * LINE_BYTES > (1 << PAGE_BITS)) begin : g_way_exceeds_page
    $error("one way is larger than a page; indexing would need translated bits");
  end

  logic [PGL_W-1:0]  pg_line;
  logic [IDX_W-1:0]  idx, wr_idx;
  logic [WAYS-1:0]   way_hit, way_valid, wr_way;
  logic              wr_en;
  logic [PPN_W-1:0]  wr_tag;
  logic              unused_vbits;

  assign pg_line      = vaddr_i[PAGE_BITS-1:OFF_W];
  assign idx          = pg_line[IDX_W-1:0];
  assign unused_vbits = ^{vaddr_i[ADDR_W-1:PAGE_BITS], vaddr_i[BYTE_W-1:0]};

  pipt_tag_store #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(PPN_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .cmp_tag(tlb_ppn_i),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .way_hit(way_hit), .way_valid(way_valid)
  );

  pipt_data_store #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W),
                    .WSEL_W(WSEL_W), .WORD_W(WORD_W)) data_i (
    .clk(clk), .rd_idx(idx), .rd_sel(vaddr_i[BYTE_W +: WSEL_W]), .way_hit(way_hit),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_line(refill_data_i),
    .rd_word(rdata_o)
  );

  pipt_fill_ctrl #(.SETS(SETS), .IDX_W(IDX_W), .PPN_W(PPN_W), .PGL_W(PGL_W),
                   .OFF_W(OFF_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req(req_i), .tlb_hit(tlb_hit_i), .ppn(tlb_ppn_i),
    .pg_line(pg_line), .way_hit(way_hit), .way_valid(way_valid),
    .refill_valid(refill_valid_i), .hit(hit_o), .miss(miss_o),
    .refill_req(refill_req_o), .refill_addr(refill_addr_o),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_tag(wr_tag)
  );
endmodule

// File: rtl/pipt_l1_cache_chk.sv
module pipt_l1_cache_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              tlb_hit_i,
  input logic              hit_o,
  input logic              miss_o,
  input logic              refill_req_o,
  input logic              refill_valid_i,
  input logic [ADDR_W-1:0] refill_addr_o
);
  assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  assert_tlb_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !tlb_hit_i) |-> (!hit_o && !miss_o));

  assert_miss_opens_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> refill_req_o);

  assert_refill_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req_o && !refill_valid_i) |=> (refill_req_o && $stable(refill_addr_o)));

  assert_refill_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_o |-> (!hit_o && !miss_o));

  assert_refill_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_o |-> (refill_addr_o[OFF_W-1:0] == '0));

  assert_refill_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req_o && refill_valid_i) |=> !refill_req_o);
endmodule

bind pipt_l1_cache pipt_l1_cache_chk #(.ADDR_W(ADDR_W), .OFF_W($clog2(LINE_BYTES))) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .tlb_hit_i(tlb_hit_i), .hit_o(hit_o),
  .miss_o(miss_o), .refill_req_o(refill_req_o), .refill_valid_i(refill_valid_i),
  .refill_addr_o(refill_addr_o)
);

// File: tb/pipt_l1_cache_tb_top.sv
`timescale 1ns/1ps
module pipt_l1_cache_tb_top;
  logic         clk, rst_n, req, tlbh, rvalid;
  logic [31:0]  vaddr, rdata, raddr;
  logic [19:0]  ppn;
  logic [255:0] rline;
  logic         hit, miss, rreq;
  int           n_chk, n_fail;

  pipt_l1_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .vaddr_i(vaddr), .tlb_hit_i(tlbh),
    .tlb_ppn_i(ppn), .rdata_o(rdata), .hit_o(hit), .miss_o(miss),
    .refill_req_o(rreq), .refill_addr_o(raddr), .refill_valid_i(rvalid),
    .refill_data_i(rline)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [31:0] mem_word(input logic [31:0] pa);
    return pa ^ {pa[15:0], pa[31:16]} ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] la);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = mem_word({la[31:5], k[2:0], 2'b00});
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // One access; on a miss the bench serves the refill and checks the replay.
  task automatic access(input logic [31:0] va, input logic th, input logic [19:0] pn,
                        input bit exp_hit, input string rq);
    logic [31:0] pa;
    pa = {pn, va[11:0]};
    @(negedge clk);
    req = 1'b1; vaddr = va; tlbh = th; ppn = pn;
    #1;
    if (!th) begin
      check(!hit && !miss, {rq, " R6 quiet"}, {30'd0, hit, miss}, 32'd0);
      @(negedge clk); #1;
      check(!rreq, {rq, " R6 no refill"}, {31'd0, rreq}, 32'd0);
      req = 1'b0;
      return;
    end
    check(hit == exp_hit && miss == !exp_hit, {rq, " R3 hit/miss"}, {30'd0, hit, miss},
          {30'd0, exp_hit, !exp_hit});
    if (hit) check(rdata == mem_word(pa), {rq, " R5 data"}, rdata, mem_word(pa));
    if (miss) begin
      @(negedge clk); #1;
      check(rreq && !hit && !miss, {rq, " R7 refill req"}, {29'd0, rreq, hit, miss}, 32'd4);
      check(raddr == {pa[31:5], 5'd0}, {rq, " R7 refill addr"}, raddr, {pa[31:5], 5'd0});
      @(negedge clk);
      rvalid = 1'b1; rline = line_of(raddr);
      @(negedge clk);
      rvalid = 1'b0; #1;
      check(hit && !miss, {rq, " R8 replay hit"}, {30'd0, hit, miss}, 32'd2);
      check(rdata == mem_word(pa), {rq, " R8 replay data"}, rdata, mem_word(pa));
    end
    @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  localparam logic [19:0] PA = 20'h12345, PB = 20'h0ABCD, PC = 20'h77777, PD = 20'h5F00F;

  initial begin
    n_chk = 0; n_fail = 0;
    req = 0; vaddr = 0; tlbh = 0; ppn = 0; rvalid = 0; rline = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(!rreq && !hit && !miss, "R10 reset idle", {29'd0, rreq, hit, miss}, 32'd0);

    // R10/R8/R5: every set misses first, then all eight words hit.
    for (int s = 0; s < 128; s++) begin
      access({20'h00001, s[6:0], 5'd0}, 1'b1, PA, 1'b0, "R10 first");
      for (int k = 1; k < 8; k++)
        access({20'h00001, s[6:0], k[2:0], 2'b00}, 1'b1, PA, 1'b1, "R5 word");
    end
    // R1: different VPN, same offset and PPN hits.
    for (int s = 0; s < 128; s++)
      access({20'hFEDCB, s[6:0], 3'd3, 2'b00}, 1'b1, PA, 1'b1, "R1 vpn");
    // R4 then R2: same VA with another PPN misses, then both pages are resident.
    for (int s = 0; s < 128; s++) begin
      access({20'h00001, s[6:0], 5'd4}, 1'b1, PB, 1'b0, "R4 ppn");
      access({20'h00001, s[6:0], 5'd8}, 1'b1, PA, 1'b1, "R2 way A");
      access({20'h00001, s[6:0], 5'd12}, 1'b1, PB, 1'b1, "R2 way B");
    end
    // R9: in set 5 the recency now points at A.
    access({20'h0, 7'd5, 5'd0}, 1'b1, PC, 1'b0, "R9 C evicts A");
    access({20'h0, 7'd5, 5'd0}, 1'b1, PB, 1'b1, "R9 B kept");
    access({20'h0, 7'd5, 5'd0}, 1'b1, PA, 1'b0, "R9 A evicts C");
    access({20'h0, 7'd5, 5'd0}, 1'b1, PB, 1'b1, "R9 B still");
    access({20'h0, 7'd5, 5'd0}, 1'b1, PC, 1'b0, "R9 C gone");
    // R6: TLB miss on resident and on absent pages.
    access({20'h0, 7'd9, 5'd0}, 1'b0, PA, 1'b0, "R6 resident");
    access({20'h0, 7'd9, 5'd0}, 1'b0, PD, 1'b0, "R6 absent");
    access({20'h0, 7'd9, 5'd0}, 1'b1, PD, 1'b0, "R6 no alloc");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule